// File: doc/BRIEF.md
# Clock source switch controller

This block picks the system oscillator from eight candidate clocks using a 3-bit code. The code taken after reset comes from a configuration input. Software requests a change by writing a target code together with a switch-enable bit. The block then moves the output onto the new clock without glitches. It reports the active code, whether the PLL output can be trusted, and a sticky clock-fail flag. A fail-safe monitor raises that flag when the selected clock stops. The monitor measures against the low-power RC clock and then forces a fallback to the fast RC oscillator.

All logic runs on one fast control clock. The oscillator inputs are oversampled on that clock, so every source must run well below the control clock rate. The block also contains a power-of-two divider on the fast RC path, a clock-lock bit that freezes the selection, a PLL start-up timer, and the divide-by-2 that forms the instruction clock.

Top module: `clk_src_switch`

## Requirements
- R1: While reset is asserted, both `cur_src` and `new_src` load `cfg_src`. `oswen`, `clklock` and `clk_fail` read 0, and `frcdiv` reads 000.
- R2: The source codes map as follows: 000 fast RC, 001 and 011 the PLL output, 010 primary, 100 secondary, 101 low-power RC, 110 fast RC divided by 16, 111 fast RC divided by N. `osc_out` has the period of the selected clock.
- R3: A write with `wr_oswen`=1 and a `wr_nosc` different from `cur_src` starts a switch when the block is idle and not locked. `oswen` reads 1 from the next cycle on. It returns to 0 on the same edge at which `cur_src` takes the new code. Target and enable writes made during a switch are ignored.
- R4: A write with `wr_oswen`=1 and `wr_nosc` equal to `cur_src` updates `new_src` only. `oswen` stays 0 and `cur_src` does not change.
- R5: While `clklock`=1 and `fscm_en`=0, writes leave `new_src` unchanged and start no switch. With `fscm_en`=1 the lock has no effect. `clklock` and `frcdiv` take every write.
- R6: Divider code k in `frcdiv` gives a period of 2^(k+1) fast RC periods on source 111, from 000 (÷2) to 111 (÷256). A new code takes effect when the internal 8-bit edge counter wraps to zero. Source 110 always divides by 16.
- R7: `cyc_out` toggles on each rising edge of `osc_out`, so its period is twice the period of `osc_out`.
- R8: A switch drives `osc_out` low once the old clock is low. It waits for two rising edges of the new clock and moves over while the new clock is low. No high or low phase of `osc_out` is shorter than the shorter half period of the two clocks.
- R9: `lock_sts` is 0 when `cur_src` is not 001 or 011. On a PLL source, it is 1 when `pll_lock` is 1 or when LOCK_WAIT control cycles have passed since the source became active.
- R10: With `fscm_en`=1 and no switch running, suppose three rising edges of the low-power RC clock pass with no rising edge of the selected clock. Then `clk_fail` sets, `new_src` becomes 000, and the block switches to 000.
- R11: `clk_fail` is cleared only by `cf_clr` and cannot be set by a write. A failure detected in the same cycle as a clear leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | control clock that samples all oscillators |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_src | input | 3 | source code loaded at reset |
| fscm_en | input | 1 | enables the fail-safe monitor |
| frc_clk | input | 1 | fast RC oscillator |
| pll_clk | input | 1 | PLL output clock |
| pri_clk | input | 1 | primary oscillator |
| sec_clk | input | 1 | secondary oscillator |
| lprc_clk | input | 1 | low-power RC oscillator, monitor reference |
| pll_lock | input | 1 | lock indication from the PLL |
| wr_en | input | 1 | control register write strobe |
| wr_nosc | input | 3 | target source code to write |
| wr_oswen | input | 1 | switch-enable value to write |
| wr_clklock | input | 1 | clock-lock value to write |
| wr_frcdiv | input | 3 | fast RC divider code to write |
| cf_clr | input | 1 | clears the clock-fail flag |
| cur_src | output | 3 | active source code |
| new_src | output | 3 | requested source code |
| oswen | output | 1 | switch in progress |
| clklock | output | 1 | clock-lock bit |
| lock_sts | output | 1 | PLL lock status |
| clk_fail | output | 1 | sticky clock-fail flag |
| frcdiv | output | 3 | fast RC divider code |
| osc_out | output | 1 | selected oscillator output |
| cyc_out | output | 1 | instruction clock, `osc_out` divided by 2 |

## Verification
The bench builds the block with LOCK_WAIT=20 and SYNC_STAGES=2. The short start-up timer lets the timed path of the lock status be checked apart from `pll_lock` within a few dozen cycles. The source clocks have fixed integer periods of 6, 4, 10, 14 and 40 control cycles. With these, every divider setting up to ÷256 can be measured exactly. They also keep the secondary clock fast enough for the monitor, so the monitor trips only when the bench stops that clock.

// File: rtl/clk_src_switch.sv
module clk_src_switch #(
  parameter int LOCK_WAIT   = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cfg_src,
  input  logic       fscm_en,
  input  logic       frc_clk,
  input  logic       pll_clk,
  input  logic       pri_clk,
  input  logic       sec_clk,
  input  logic       lprc_clk,
  input  logic       pll_lock,
  input  logic       wr_en,
  input  logic [2:0] wr_nosc,
  input  logic       wr_oswen,
  input  logic       wr_clklock,
  input  logic [2:0] wr_frcdiv,
  input  logic       cf_clr,
  output logic [2:0] cur_src,
  output logic [2:0] new_src,
  output logic       oswen,
  output logic       clklock,
  output logic       lock_sts,
  output logic       clk_fail,
  output logic [2:0] frcdiv,
  output logic       osc_out,
  output logic       cyc_out
);
  localparam int TW = $clog2(LOCK_WAIT + 1);
  localparam int SW = $clog2(SYNC_STAGES + 1);

  typedef enum logic [1:0] {RUN, DRAIN, SYNC, ARM} st_t;

  st_t           st;
  logic [4:0]    smp;
  logic [7:0]    lv, lv_d, rise;
  logic [7:0]    dcnt;
  logic [2:0]    dsel, tgt;
  logic          gate, osc_d;
  logic [SW-1:0] scnt;
  logic [1:0]    ref_n;
  logic [TW-1:0] tmr;
  logic          blocked, fail_hit, pll_src;

  assign lv       = {dcnt[dsel], dcnt[3], smp[4], smp[3], smp[1], smp[2], smp[1], smp[0]};
  assign rise     = lv & ~lv_d;
  assign blocked  = clklock & ~fscm_en;
  assign fail_hit = fscm_en & ~rise[cur_src] & rise[5] & (ref_n == 2'd2);
  assign pll_src  = (cur_src == 3'b001) | (cur_src == 3'b011);
  assign lock_sts = pll_src & (pll_lock | (tmr == TW'(LOCK_WAIT)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp  <= '0;
      lv_d <= '0;
      dcnt <= '0;
      dsel <= '0;
    end else begin
      smp  <= {lprc_clk, sec_clk, pri_clk, pll_clk, frc_clk};
      lv_d <= lv;
      if (rise[0]) dcnt <= dcnt + 8'd1;
      if (dcnt == 8'd0) dsel <= frcdiv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RUN;
      cur_src  <= cfg_src;
      new_src  <= cfg_src;
      tgt      <= cfg_src;
      oswen    <= 1'b0;
      clklock  <= 1'b0;
      frcdiv   <= 3'b000;
      clk_fail <= 1'b0;
      gate     <= 1'b1;
      scnt     <= '0;
      ref_n    <= '0;
    end else begin
      if (wr_en) begin
        clklock <= wr_clklock;
        frcdiv  <= wr_frcdiv;
      end
      if (cf_clr) clk_fail <= 1'b0;
      case (st)
        RUN: begin
          if (fail_hit) begin
            clk_fail <= 1'b1;
            new_src  <= 3'b000;
            tgt      <= 3'b000;
            gate     <= 1'b0;
            scnt     <= '0;
            ref_n    <= '0;
            st       <= SYNC;
          end else begin
            if (!fscm_en || rise[cur_src]) ref_n <= '0;
            else if (rise[5])              ref_n <= ref_n + 2'd1;
            if (wr_en && !blocked) begin
              new_src <= wr_nosc;
              if (wr_oswen && (wr_nosc != cur_src)) begin
                oswen <= 1'b1;
                tgt   <= wr_nosc;
                st    <= DRAIN;
              end
            end
          end
        end
        DRAIN: begin
          ref_n <= '0;
          if (!lv[cur_src]) begin
            gate <= 1'b0;
            scnt <= '0;
            st   <= SYNC;
          end
        end
        SYNC: begin
          ref_n <= '0;
          if (rise[tgt]) begin
            if (scnt == SW'(SYNC_STAGES - 1)) st <= ARM;
            else scnt <= scnt + 1'b1;
          end
        end
        default: begin
          ref_n <= '0;
          if (!lv[tgt]) begin
            cur_src <= tgt;
            gate    <= 1'b1;
            oswen   <= 1'b0;
            st      <= RUN;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_out <= 1'b0;
      osc_d   <= 1'b0;
      cyc_out <= 1'b0;
      tmr     <= '0;
    end else begin
      osc_out <= gate & lv[cur_src];
      osc_d   <= osc_out;
      if (osc_out && !osc_d) cyc_out <= ~cyc_out;
      if (!pll_src || st != RUN)      tmr <= '0;
      else if (tmr != TW'(LOCK_WAIT)) tmr <= tmr + 1'b1;
    end
  end

  a_r3_oswen_drop_moves_src: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oswen) |-> (cur_src != $past(cur_src)));

  a_r3_src_moves_only_from_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_src != $past(cur_src)) |-> $past(st == ARM));

  a_r8_output_quiet_in_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SYNC || st == ARM) |=> !osc_out);

  a_r5_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && clklock && !fscm_en && st == RUN) |=> ($stable(new_src) && !$rose(oswen)));

  a_r10_fail_needs_monitor: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_fail) |-> $past(fscm_en));

  a_r11_clear_without_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_clr && !fail_hit) |=> !clk_fail);
endmodule

// File: tb/test_clk_src_switch.sv
module test_clk_src_switch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_src = 3'b010;
  logic       fscm_en = 1'b0;
  logic       frc_clk, pll_clk, pri_clk, sec_clk, lprc_clk;
  logic       pll_lock = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_nosc = 3'b000;
  logic       wr_oswen = 1'b0;
  logic       wr_clklock = 1'b0;
  logic [2:0] wr_frcdiv = 3'b000;
  logic       cf_clr = 1'b0;
  logic [2:0] cur_src, new_src, frcdiv;
  logic       oswen, clklock, lock_sts, clk_fail, osc_out, cyc_out;

  int ntests = 0, nfail = 0, cycles = 0, glitches = 0;
  int c_frc = 0, c_pll = 0, c_pri = 0, c_sec = 0, c_lprc = 0;
  bit sec_run = 1'b1, fbw = 1'b0, done = 1'b0, armed = 1'b0;
  logic [2:0] m_cur = 3'b010, m_new = 3'b010, m_tgt = 3'b000, m_div = 3'b000;
  bit m_pend = 1'b0, m_lock = 1'b0, m_cf = 1'b0;
  int run_len = 0;
  logic last_osc = 1'b0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    c_frc  <= (c_frc  == 5)  ? 0 : c_frc + 1;
    c_pll  <= (c_pll  == 3)  ? 0 : c_pll + 1;
    c_pri  <= (c_pri  == 9)  ? 0 : c_pri + 1;
    c_sec  <= (c_sec  == 13) ? 0 : c_sec + 1;
    c_lprc <= (c_lprc == 39) ? 0 : c_lprc + 1;
  end
  assign frc_clk  = c_frc < 3;
  assign pll_clk  = c_pll < 2;
  assign pri_clk  = c_pri < 5;
  assign sec_clk  = sec_run && (c_sec < 7);
  assign lprc_clk = c_lprc < 20;

  clk_src_switch #(.LOCK_WAIT(20), .SYNC_STAGES(2)) i_clk_src_switch (
    .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .fscm_en(fscm_en),
    .frc_clk(frc_clk), .pll_clk(pll_clk), .pri_clk(pri_clk), .sec_clk(sec_clk),
    .lprc_clk(lprc_clk), .pll_lock(pll_lock), .wr_en(wr_en), .wr_nosc(wr_nosc),
    .wr_oswen(wr_oswen), .wr_clklock(wr_clklock), .wr_frcdiv(wr_frcdiv), .cf_clr(cf_clr),
    .cur_src(cur_src), .new_src(new_src), .oswen(oswen), .clklock(clklock),
    .lock_sts(lock_sts), .clk_fail(clk_fail), .frcdiv(frcdiv),
    .osc_out(osc_out), .cyc_out(cyc_out));

  task automatic chk(input string req, input int act, input int exp);
    ntests++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model compared every cycle
  always @(posedge clk) begin
    #2;
    if (rst_n && !fbw) begin
      chk("R5 new_src vs model", new_src, m_new);
      chk("R5 clklock vs model", clklock, m_lock);
      chk("R6 frcdiv vs model", frcdiv, m_div);
      chk("R11 clk_fail vs model", clk_fail, m_cf);
      if (m_pend && !oswen) begin
        chk("R3 cur_src at switch end", cur_src, m_tgt);
        m_cur = m_tgt;
        m_pend = 1'b0;
      end else begin
        chk("R3 oswen vs model", oswen, m_pend);
        chk("R3 cur_src vs model", cur_src, m_cur);
      end
    end
  end

  // R8 monitor: no phase of osc_out shorter than two control cycles
  always @(negedge clk) begin
    if (rst_n && armed) begin
      if (osc_out == last_osc) run_len++;
      else begin
        if (run_len < 2 && !fbw) begin
          glitches++;
          $display("FAIL R8 short phase actual=%0d expected>=2 at %0t", run_len, $time);
        end
        run_len = 1;
        last_osc = osc_out;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      nfail++;
      ntests++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] nosc, input logic ose, input logic lk, input logic [2:0] dv);
    bit blk, idle;
    @(negedge clk);
    wr_en = 1'b1; wr_nosc = nosc; wr_oswen = ose; wr_clklock = lk; wr_frcdiv = dv;
    @(posedge clk);
    blk  = m_lock && !fscm_en;
    idle = !m_pend;
    m_lock = lk;
    m_div  = dv;
    if (!blk && idle) begin
      m_new = nosc;
      if (ose && nosc != m_cur) begin
        m_pend = 1'b1;
        m_tgt  = nosc;
      end
    end
    @(negedge clk);
    wr_en = 1'b0; wr_oswen = 1'b0;
  endtask

  task automatic wait_switch(input string req);
    int n = 0;
    while (m_pend && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk(req, m_pend, 0);
  endtask

  function automatic logic pick(input bit use_cyc);
    return use_cyc ? cyc_out : osc_out;
  endfunction

  task automatic get_per(input bit use_cyc, output int p);
    int n = 0;
    logic a, b;
    bit rose = 1'b0;
    @(negedge clk);
    a = pick(use_cyc);
    while (!rose && n < 6000) begin
      @(negedge clk);
      b = pick(use_cyc); rose = b && !a; a = b; n++;
    end
    p = 0; rose = 1'b0;
    while (!rose && p < 6000) begin
      @(negedge clk);
      b = pick(use_cyc); rose = b && !a; a = b; p++;
    end
  endtask

  initial begin
    int p;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 cur_src reset", cur_src, 3'b010);
    chk("R1 new_src reset", new_src, 3'b010);
    chk("R1 oswen reset", oswen, 0);
    chk("R1 clklock reset", clklock, 0);
    chk("R1 clk_fail reset", clk_fail, 0);
    chk("R1 frcdiv reset", frcdiv, 0);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    armed = 1'b1;
    last_osc = osc_out;
    get_per(1'b0, p); chk("R2 primary period", p, 10);

    wr(3'b000, 1'b1, 1'b0, 3'b000);
    chk("R3 oswen set after request", oswen, 1);
    wait_switch("R3 switch to 000 completes");
    chk("R3 cur_src 000", cur_src, 3'b000);
    get_per(1'b0, p); chk("R2 fast RC period", p, 6);
    get_per(1'b1, p); chk("R7 instruction clock on fast RC", p, 12);

    wr(3'b000, 1'b1, 1'b0, 3'b000);
    chk("R4 same source keeps oswen 0", oswen, 0);
    repeat (20) @(negedge clk);
    chk("R4 same source keeps cur_src", cur_src, 3'b000);

    wr(3'b111, 1'b1, 1'b0, 3'b000);
    wait_switch("R6 switch to 111 completes");
    for (int k = 0; k < 8; k++) begin
      wr(3'b111, 1'b0, 1'b0, 3'(k));
      repeat (1600) @(negedge clk);
      get_per(1'b0, p);
      chk($sformatf("R6 divide code %0d period", k), p, 6 * (2 << k));
    end

    wr(3'b110, 1'b1, 1'b0, 3'b111);
    wait_switch("R6 switch to 110 completes");
    get_per(1'b0, p); chk("R6 fixed divide by 16 period", p, 96);

    wr(3'b001, 1'b1, 1'b0, 3'b000);
    wait_switch("R9 switch to 001 completes");
    chk("R9 lock_sts low while timer runs", lock_sts, 0);
    repeat (30) @(negedge clk);
    chk("R9 lock_sts high after timer", lock_sts, 1);
    get_per(1'b0, p); chk("R2 PLL period on 001", p, 4);
    get_per(1'b1, p); chk("R7 instruction clock on PLL", p, 8);
    wr(3'b010, 1'b1, 1'b0, 3'b000);
    wait_switch("R9 switch to 010 completes");
    repeat (30) @(negedge clk);
    chk("R9 lock_sts low on non-PLL source", lock_sts, 0);
    pll_lock = 1'b1;
    wr(3'b011, 1'b1, 1'b0, 3'b000);
    wait_switch("R9 switch to 011 completes");
    chk("R9 lock_sts follows pll_lock at once", lock_sts, 1);
    get_per(1'b0, p); chk("R2 PLL period on 011", p, 4);

    wr(3'b011, 1'b0, 1'b1, 3'b000);
    chk("R5 clklock set", clklock, 1);
    wr(3'b100, 1'b1, 1'b1, 3'b000);
    chk("R5 locked write keeps new_src", new_src, 3'b011);
    chk("R5 locked write starts no switch", oswen, 0);
    repeat (20) @(negedge clk);
    chk("R5 locked cur_src unchanged", cur_src, 3'b011);
    fscm_en = 1'b1;
    wr(3'b100, 1'b1, 1'b1, 3'b000);
    chk("R5 monitor on overrides lock", oswen, 1);
    wait_switch("R5 switch to 100 completes");
    wr(3'b100, 1'b0, 1'b0, 3'b000);
    get_per(1'b0, p); chk("R2 secondary period", p, 14);
    repeat (200) @(negedge clk);
    chk("R10 no false fail on running clock", clk_fail, 0);

    fbw = 1'b1;
    sec_run = 1'b0;
    for (int n = 0; n < 500 && !clk_fail; n++) @(negedge clk);
    chk("R10 clk_fail set on dead clock", clk_fail, 1);
    chk("R10 new_src forced to 000", new_src, 3'b000);
    for (int n = 0; n < 500 && cur_src != 3'b000; n++) @(negedge clk);
    chk("R10 fallback to 000", cur_src, 3'b000);
    @(negedge clk);
    m_cur = 3'b000; m_new = 3'b000; m_cf = 1'b1;
    fscm_en = 1'b0;
    sec_run = 1'b1;
    fbw = 1'b0;
    get_per(1'b0, p); chk("R10 fast RC period after fallback", p, 6);
    wr(3'b000, 1'b0, 1'b0, 3'b000);
    chk("R11 write does not clear clk_fail", clk_fail, 1);

    @(negedge clk); cf_clr = 1'b1;
    @(posedge clk); m_cf = 1'b0;
    @(negedge clk); cf_clr = 1'b0;
    chk("R11 cf_clr clears clk_fail", clk_fail, 0);

    wr(3'b101, 1'b1, 1'b0, 3'b000);
    wait_switch("R2 switch to 101 completes");
    get_per(1'b0, p); chk("R2 low-power RC period", p, 40);

    chk("R8 short phases seen", glitches, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule